// File: doc/BRIEF.md
# Spread-Spectrum Triangle Dither Generator

This block produces the digital frequency-offset code that steers a center-dithered spread-spectrum clock. It runs from the master clock. A rate divider, set by a two-bit rate selector, turns the master clock into a step enable every 4, 8, 16 or 32 cycles. Each step moves a 128-step triangle sequencer by one count. The sequence starts at the center, climbs to the positive peak, falls to the negative peak and climbs back to the center. The modulation period is therefore 512, 1024, 2048 or 4096 master cycles.

The triangle value is scaled by a two-bit amplitude selector into a signed offset code that is symmetric about zero. Zero stands for the programmed center frequency, and the peak codes 32, 64 and 128 stand for ±1 %, ±2 % and ±4 % deviation (2 %, 4 % or 8 % total swing). With dither off, the code stays at zero. A single-cycle step strobe comes out with the code, so a consumer or bench can time the waveform. A separate fixed prescaler gives an enable for the output clock every 2^OUT_DIV_LOG2 master cycles.

Top module: `dither_tri_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `offset_o` is 0 and `step_o` and `out_en_o` are 0. The first strobe comes on the D-th rising edge after reset is released, where D is the step interval for the rate code sampled during reset.
- R2: The step interval D is set by `rate_sel`: code 0 gives 4 cycles, 1 gives 8, 2 gives 16 and 3 gives 32. `step_o` pulses once every D master cycles.
- R3: The triangle starts at 0 heading up. On each step it moves by exactly 1. It turns at +32 and at -32 with no repeated value, so one period is 128 steps and each half is 64 steps.
- R4: Amplitude codes on `amp_sel` scale the triangle as follows: 1 gives ×1 (peak ±32), 2 gives ×2 (peak ±64) and 3 gives ×4 (peak ±128). The result is sign-extended into the 9-bit `offset_o`.
- R5: Amplitude code 0 (dither off) holds `offset_o` at 0 for every step taken under it. The triangle keeps stepping underneath, so the waveform carries on in phase when dither is turned back on.
- R6: `rate_sel` and `amp_sel` are sampled only at a step boundary. `offset_o` never changes in a cycle without a strobe. A new rate sets the length of the interval that starts at the next strobe.
- R7: `step_o` is one cycle wide. `offset_o` takes its new value in the same cycle in which `step_o` is high.
- R8: `out_en_o` is high after rising edge k from reset release exactly when k is a multiple of 2^OUT_DIV_LOG2 (default 4). It does not depend on `rate_sel` or `amp_sel`.
- R9: With the selectors held, rising zero-crossings of the offset repeat every 128×D master cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Step interval select (4/8/16/32 cycles) |
| amp_sel | input | 2 | Amplitude select (off, ×1, ×2, ×4) |
| offset_o | output | 9 | Signed frequency-offset code, 0 = center |
| step_o | output | 1 | Single-cycle strobe at each triangle step |
| out_en_o | output | 1 | Fixed output-clock prescaler enable |

## Verification
On every cycle the assertions check these properties:
- the triangle stays within ±32 and moves by exactly one per step;
- the triangle holds still between steps;
- the offset is zero while dither is off;
- the offset changes only together with a one-cycle strobe;
- the output-clock enable is never high on two cycles in a row.

Some behaviours need the bench's reference model and its scenarios:
- the actual step intervals for each rate code, and the exact offset values for each amplitude;
- the deferral of pin changes made in the middle of a step;
- the phase continuity after dither is switched off and back on;
- the full modulation period, which the bench measures across zero-crossings.

// File: rtl/dither_pkg.sv
package dither_pkg;
  typedef enum logic [1:0] {
    AMP_OFF = 2'd0,
    AMP_X1  = 2'd1,
    AMP_X2  = 2'd2,
    AMP_X4  = 2'd3
  } amp_e;
endpackage

// File: rtl/dither_rate_div.sv
module dither_rate_div #(
  parameter int RATE_BASE_LOG2 = 2,
  localparam int CNT_W = RATE_BASE_LOG2 + 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] rate_sel,
  output logic       tick,
  output logic       step_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       rate_q;
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] last;

  assign span = (CNT_W+1)'(1) << (RATE_BASE_LOG2 + int'(rate_q));
  assign last = CNT_W'(span - (CNT_W+1)'(1));
  assign tick = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rate_q <= rate_sel;
      step_q <= 1'b0;
    end else begin
      step_q <= tick;
      if (tick) begin
        cnt_q  <= '0;
        rate_q <= rate_sel;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R2: the divider never runs past the interval of the latched rate
  assert_cnt_in_span_R2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt_q} < span);

  // R6: the latched rate only moves on a step boundary
  assert_rate_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(rate_q));
endmodule

// File: rtl/dither_tri_seq.sv
module dither_tri_seq #(
  parameter int STEPS = 128,
  localparam int PEAK = STEPS / 4,
  localparam int TRI_W = $clog2(PEAK) + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  output logic signed [TRI_W-1:0] tri_nxt,
  output logic signed [TRI_W-1:0] tri_q
);
  localparam logic signed [TRI_W-1:0] TOP_M1 = TRI_W'(PEAK - 1);
  localparam logic signed [TRI_W-1:0] BOT_P1 = -TOP_M1;
  localparam logic signed [TRI_W-1:0] TOP    = TRI_W'(PEAK);
  localparam logic signed [TRI_W-1:0] ONE    = TRI_W'(1);

  logic up_q;
  logic up_nxt;

  always_comb begin
    tri_nxt = tri_q;
    up_nxt  = up_q;
    if (tick) begin
      if (up_q) begin
        tri_nxt = tri_q + ONE;
        up_nxt  = (tri_q != TOP_M1);
      end else begin
        tri_nxt = tri_q - ONE;
        up_nxt  = (tri_q == BOT_P1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tri_q <= '0;
      up_q  <= 1'b1;
    end else begin
      tri_q <= tri_nxt;
      up_q  <= up_nxt;
    end
  end

  // R3: triangle stays within the peaks
  assert_tri_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (tri_q <= TOP) && (tri_q >= -TOP));

  // R3: each step moves the triangle by exactly one
  assert_tri_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((tri_q == $past(tri_q) + ONE) || (tri_q == $past(tri_q) - ONE)));

  // R6: no motion between steps
  assert_tri_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tri_q));
endmodule

// File: rtl/dither_amp_scale.sv
module dither_amp_scale
  import dither_pkg::*;
#(
  parameter int TRI_W = 7,
  localparam int OFS_W = TRI_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic [1:0]              amp_sel,
  input  logic signed [TRI_W-1:0] tri_nxt,
  output logic signed [OFS_W-1:0] offset_q
);
  logic                    [1:0] amp_q;
  logic signed [OFS_W-1:0] ext;
  logic signed [OFS_W-1:0] scaled;

  assign ext = {{2{tri_nxt[TRI_W-1]}}, tri_nxt};

  always_comb begin
    case (amp_e'(amp_sel))
      AMP_X1:  scaled = ext;
      AMP_X2:  scaled = ext <<< 1;
      AMP_X4:  scaled = ext <<< 2;
      default: scaled = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_q    <= 2'd0;
      offset_q <= '0;
    end else if (tick) begin
      amp_q    <= amp_sel;
      offset_q <= scaled;
    end
  end

  // R5: dither off keeps the code at center
  assert_off_center_R5: assert property (@(posedge clk) disable iff (rst)
    (amp_q == 2'd0) |-> (offset_q == '0));

  // R6: code moves only at a step boundary
  assert_offset_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(offset_q));
endmodule

// File: rtl/dither_out_prescale.sv
module dither_out_prescale #(
  parameter int OUT_DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  output logic out_en_q
);
  generate
    if (OUT_DIV_LOG2 == 0) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) out_en_q <= 1'b0;
        else     out_en_q <= 1'b1;
      end
    end else begin : g_div
      logic [OUT_DIV_LOG2-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt_q    <= '0;
          out_en_q <= 1'b0;
        end else begin
          cnt_q    <= cnt_q + OUT_DIV_LOG2'(1);
          out_en_q <= (cnt_q == '1);
        end
      end

      // R8: enable pulses are isolated when dividing
      assert_en_isolated_R8: assert property (@(posedge clk) disable iff (rst)
        out_en_q |=> !out_en_q);
    end
  endgenerate
endmodule

// File: rtl/dither_tri_gen.sv
module dither_tri_gen #(
  parameter int RATE_BASE_LOG2 = 2,
  parameter int STEPS          = 128,
  parameter int OUT_DIV_LOG2   = 2,
  localparam int PEAK  = STEPS / 4,
  localparam int TRI_W = $clog2(PEAK) + 2,
  localparam int OFS_W = TRI_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              rate_sel,
  input  logic [1:0]              amp_sel,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    step_o,
  output logic                    out_en_o
);
  logic                    tick;
  logic signed [TRI_W-1:0] tri_nxt;
  logic signed [TRI_W-1:0] tri_q;

  dither_rate_div #(.RATE_BASE_LOG2(RATE_BASE_LOG2)) u_rate (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .tick(tick), .step_q(step_o)
  );

  dither_tri_seq #(.STEPS(STEPS)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .tri_nxt(tri_nxt), .tri_q(tri_q)
  );

  dither_amp_scale #(.TRI_W(TRI_W)) u_amp (
    .clk(clk), .rst(rst), .tick(tick), .amp_sel(amp_sel),
    .tri_nxt(tri_nxt), .offset_q(offset_o)
  );

  dither_out_prescale #(.OUT_DIV_LOG2(OUT_DIV_LOG2)) u_out (
    .clk(clk), .rst(rst), .out_en_q(out_en_o)
  );

  // R7: strobe is one cycle wide (intervals are at least four cycles)
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o);

  // R7: the code changes only in a strobe cycle
  assert_offset_with_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !step_o |-> $stable(offset_o));
endmodule

// File: tb/test_dither_tri_gen.sv
module test_dither_tri_gen;
  localparam int OUT_L = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        rate_sel = 2'd0;
  logic [1:0]        amp_sel = 2'd1;
  logic signed [8:0] offset_o;
  logic              step_o;
  logic              out_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dither_tri_gen i_dither_tri_gen (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .amp_sel(amp_sel),
    .offset_o(offset_o), .step_o(step_o), .out_en_o(out_en_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mcnt, mrate, mtri, mamp, eoff, edges;
  bit mup, est, een, started;

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0; mrate = int'(rate_sel); mtri = 0; mup = 1; mamp = 0;
      eoff = 0; est = 0; een = 0; edges = 0;
    end else begin
      int div;
      edges++;
      div = 4 << mrate;
      est = (mcnt == div - 1);
      if (est) begin
        mcnt = 0;
        mrate = int'(rate_sel);
        mamp = int'(amp_sel);
        if (mup) begin mtri++; if (mtri == 32) mup = 0; end
        else begin mtri--; if (mtri == -32) mup = 1; end
        eoff = (mamp == 0) ? 0 : mtri * (1 << (mamp - 1));
      end else begin
        mcnt++;
      end
      een = (edges % (1 << OUT_L)) == 0;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk(int'(offset_o) == eoff, "R3/R4/R5/R6 offset", int'(offset_o), eoff);
      chk(step_o == est, "R2/R6/R7 step", int'(step_o), int'(est));
      chk(out_en_o == een, "R8 out_en", int'(out_en_o), int'(een));
    end
  end

  // measure cycles between rising zero-crossings of the offset
  task automatic period(input int exp, input string tag);
    int prev, cyc;
    bit seen;
    prev = 0; cyc = 0; seen = 0;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      if (seen) cyc++;
      if (step_o) begin
        if (offset_o == 0 && prev < 0) begin
          if (seen) begin
            chk(cyc == exp, tag, cyc, exp);
            return;
          end
          seen = 1; cyc = 0;
        end
        prev = int'(offset_o);
      end
    end
    chk(0, tag, cyc, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(offset_o == 0 && !step_o && !out_en_o, "R1 reset", int'(offset_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(offset_o == 0 && !step_o, "R1 after release", int'(offset_o), 0);
    repeat (2) @(negedge clk);
    chk(!step_o, "R1 no early strobe", int'(step_o), 0);
    @(negedge clk);
    chk(step_o && offset_o == 1, "R1 first strobe", int'(offset_o), 1);
    period(512, "R9 period rate0");
    amp_sel = 2'd2; rate_sel = 2'd1;
    repeat (1100) @(negedge clk);
    period(1024, "R9 period rate1");
    amp_sel = 2'd3; rate_sel = 2'd2;
    repeat (2100) @(negedge clk);
    period(2048, "R9 period rate2");
    amp_sel = 2'd0; rate_sel = 2'd3;
    repeat (900) @(negedge clk);
    chk(offset_o == 0, "R5 off holds center", int'(offset_o), 0);
    amp_sel = 2'd1; rate_sel = 2'd0;
    repeat (300) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i % 5 == 0) begin
        rate_sel = 2'((i * 3) % 4);
        amp_sel  = 2'((i * 7 / 5) % 4);
      end
    end
    rst = 1'b1;
    rate_sel = 2'd1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    amp_sel = 2'd3;
    repeat (7) @(negedge clk);
    chk(!step_o, "R1 rate from reset", int'(step_o), 0);
    @(negedge clk);
    chk(step_o && offset_o == 4, "R1 rate from reset", int'(offset_o), 4);
    repeat (2000) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule